// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer

A 16-bit down counter with a reload latch and a one-byte control register. One counter serves four modes: an interval timer, a buzzer that flips an output pin on every underflow, an event counter clocked by edges of an external pin, and a pulse-width meter that counts only while that pin holds a chosen level. The count source for the timer-style modes is either the system clock directly or a divide-by-16 of it. The divide-by-16 can also run from a separate low-speed clock enable.

Software writes the latch one byte at a time and writes the control register through a small register port. A control bit chooses when a latch write reaches the counter: at once, or at the next underflow. One polarity bit sets three things together: the counted edge, the measured level, and the edge that raises the pin interrupt. Every underflow produces a one-cycle interrupt pulse. The counter value and the control register can be read back at any time.

Top module: `multi_mode_timer`

## Requirements
- R1: After reset, the counter, the latch and the control register read 0. The buzzer outputs and both interrupt outputs are low.
- R2: `wr_sel`=2 writes the control register. Its bit fields are: bit0 latch-only, bit1 complementary enable, bits 5:4 mode, bit6 polarity, bit7 stop. Bits 3:2 always read 0. `wr_sel`=3 is ignored.
- R3: In interval, buzzer and pulse-width modes with `src_fast`=0, a free-running prescaler counts base enables. A base enable is every clock, or `ls_ce` when `low_speed`=1. The prescaler issues a count on every 16th base enable, and the first one after reset comes on the 16th.
- R4: With `src_fast`=1 in those modes, the counter counts on every clock.
- R5: A count when the counter holds 0 is an underflow. The counter reloads from the latch, and `uf_irq` is high for the following cycle. A count on any other value decrements by one.
- R6: `wr_sel`=0 writes latch bits 7:0 and `wr_sel`=1 writes latch bits 15:8. With latch-only=0, the counter takes the whole updated latch value in the same cycle, and that write takes priority over counting. With latch-only=1, the write changes only the latch.
- R7: If a latch byte write and an underflow fall in the same cycle, the reload uses the latch value that includes the written byte.
- R8: Mode 01 (buzzer) inverts `buz_p` on every underflow. `buz_n` is the inverse of `buz_p` when the complementary bit is 1, and 0 when it is 0.
- R9: Mode 10 (event) counts once per synchronized edge of `ext_pin`: the rising edge when polarity=0, the falling edge when polarity=1. The pin passes through two flops before edge detection.
- R10: Mode 11 (pulse width) counts at the selected rate only while the synchronized pin is high (polarity=0) or low (polarity=1).
- R11: `edge_irq` is high for one cycle on a synchronized falling edge when polarity=0, and on a rising edge when polarity=1.
- R12: While stop=1, the counter changes only through direct writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_speed | input | 1 | Prescaler runs from `ls_ce` instead of every clock |
| ls_ce | input | 1 | Low-speed clock enable |
| src_fast | input | 1 | 1: count every clock; 0: count through the prescaler |
| ext_pin | input | 1 | External count / measure pin (asynchronous) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 latch low, 1 latch high, 2 control, 3 none |
| wr_data | input | 8 | Write data |
| cnt_out | output | 16 | Counter read-back |
| rd_mode | output | 8 | Control register read-back |
| buz_p | output | 1 | Buzzer output |
| buz_n | output | 1 | Complementary buzzer output |
| uf_irq | output | 1 | Underflow interrupt pulse |
| edge_irq | output | 1 | External pin edge interrupt pulse |

## Verification
The hardest case to reach from the ports is a latch byte write that falls on the exact cycle of an underflow while latch-only mode is set. The stimulus runs the counter at full rate from a small latch value, waits until the read-back shows 0, and writes the high byte in that same cycle. Randomized stretches switch modes, rates, polarity and pin activity while a cycle model predicts every output. This also covers prescaler phases where a count and a write coincide.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'b00,
    MODE_BUZZ     = 2'b01,
    MODE_EVENT    = 2'b10,
    MODE_PULSE    = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      stop;
    logic      pol;
    tmr_mode_e mode;
    logic [1:0] rsv;
    logic      cmp_en;
    logic      latch_only;
  } tmr_ctl_t;

  localparam logic [7:0] CTL_WR_MASK = 8'hF3;

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic base_en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick = base_en && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (base_en) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = CNT_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     lane_we,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              latch_only,
  input  logic              count_en,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  latch,
  output logic              uf_evt
);
  logic [CNT_W-1:0] cnt_q, latch_q, latch_nx;
  logic             direct;

  always_comb begin
    latch_nx = latch_q;
    for (int i = 0; i < NB; i++) begin
      if (lane_we[i]) latch_nx[i*BYTE_W +: BYTE_W] = wr_data;
    end
  end

  assign direct = (|lane_we) && !latch_only;
  assign uf_evt = !direct && count_en && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      latch_q <= '0;
    end else begin
      latch_q <= latch_nx;
      if (direct || uf_evt) begin
        cnt_q <= latch_nx;
      end else if (count_en) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt   = cnt_q;
  assign latch = latch_q;
endmodule

// File: rtl/multi_mode_timer.sv
module multi_mode_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BYTE_W      = 8,
  parameter int PRE_DIV     = 16,
  parameter int SYNC_STAGES = 2,
  localparam int NB         = CNT_W / BYTE_W,
  localparam int SEL_W      = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              low_speed,
  input  logic              ls_ce,
  input  logic              src_fast,
  input  logic              ext_pin,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CNT_W-1:0]  cnt_out,
  output logic [7:0]        rd_mode,
  output logic              buz_p,
  output logic              buz_n,
  output logic              uf_irq,
  output logic              edge_irq
);
  tmr_ctl_t         ctl_q;
  logic [NB-1:0]    lane_we;
  logic             ctl_we;
  logic             pin_lvl, pin_rise, pin_fall;
  logic             pre_tick, rate_en, count_en, uf_evt;
  logic             buz_q, uf_q;
  logic [CNT_W-1:0] latch_q;

  // byte-lane write decode, one select code per lane
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign lane_we[i] = wr_en && (wr_sel == SEL_W'(i));
  end
  assign ctl_we = wr_en && (wr_sel == SEL_W'(NB));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (ctl_we) ctl_q <= tmr_ctl_t'(wr_data[7:0] & CTL_WR_MASK);
  end

  tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
  );

  tmr_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .base_en(low_speed ? ls_ce : 1'b1),
    .tick(pre_tick)
  );

  assign rate_en = src_fast ? 1'b1 : pre_tick;

  always_comb begin
    unique case (ctl_q.mode)
      MODE_INTERVAL,
      MODE_BUZZ:  count_en = rate_en;
      MODE_EVENT: count_en = ctl_q.pol ? pin_fall : pin_rise;
      MODE_PULSE: count_en = rate_en && (pin_lvl != ctl_q.pol);
      default:    count_en = 1'b0;
    endcase
    if (ctl_q.stop) count_en = 1'b0;
  end

  tmr_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .lane_we(lane_we), .wr_data(wr_data),
    .latch_only(ctl_q.latch_only), .count_en(count_en),
    .cnt(cnt_out), .latch(latch_q), .uf_evt(uf_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buz_q <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      uf_q <= uf_evt;
      if (uf_evt && ctl_q.mode == MODE_BUZZ) buz_q <= ~buz_q;
    end
  end

  assign uf_irq   = uf_q;
  assign buz_p    = buz_q;
  assign buz_n    = ctl_q.cmp_en & ~buz_q;
  assign edge_irq = ctl_q.pol ? pin_rise : pin_fall;
  assign rd_mode  = ctl_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [7:0]       wr_data,
  input logic [CNT_W-1:0] cnt_out,
  input logic [CNT_W-1:0] latch_val,
  input logic [7:0]       rd_mode,
  input logic             uf_irq,
  input logic             buz_p
);
  assert_ctl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(2)) |=> (rd_mode == ($past(wr_data) & 8'hF3)));

  assert_reload_on_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    uf_irq |-> (cnt_out == latch_val));

  assert_direct_low_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == '0 && !rd_mode[0]) |=> (cnt_out[7:0] == $past(wr_data)));

  assert_buzzer_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_irq && $past(rd_mode[5:4]) == 2'b01) |-> (buz_p != $past(buz_p)));

  assert_stop_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode[7] && !wr_en) |=> $stable(cnt_out));
endmodule

bind multi_mode_timer tmr_checker #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .cnt_out(cnt_out), .latch_val(latch_q), .rd_mode(rd_mode),
  .uf_irq(uf_irq), .buz_p(buz_p)
);

// File: tb/tb_multi_mode_timer.sv
`timescale 1ns/1ps
module tb_multi_mode_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic low_speed = 0, ls_ce = 0, src_fast = 0, ext_pin = 0, wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [15:0] cnt_out;
  logic [7:0]  rd_mode;
  logic buz_p, buz_n, uf_irq, edge_irq;

  int checks = 0, errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  multi_mode_timer dut (
    .clk(clk), .rst_n(rst_n), .low_speed(low_speed), .ls_ce(ls_ce),
    .src_fast(src_fast), .ext_pin(ext_pin), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cnt_out(cnt_out), .rd_mode(rd_mode),
    .buz_p(buz_p), .buz_n(buz_n), .uf_irq(uf_irq), .edge_irq(edge_irq)
  );

  // ---------------- reference model built from the requirements ----------
  logic [15:0] m_cnt, m_lat;
  logic [7:0]  m_ctl;
  logic [3:0]  m_pre;
  logic m_s1, m_s2, m_prv, m_buz, m_uf;

  function automatic logic f_count_en(logic [7:0] ctl, logic fos, logic s2, logic prv);
    logic rise, fall;
    rise = s2 & ~prv;
    fall = ~s2 & prv;
    if (ctl[7]) return 1'b0;
    case (ctl[5:4])
      2'b00, 2'b01: return fos;
      2'b10:        return ctl[6] ? fall : rise;
      default:      return fos && (s2 != ctl[6]);
    endcase
  endfunction

  function automatic logic [15:0] f_merge(logic [15:0] lat, logic we, logic [1:0] sel, logic [7:0] d);
    logic [15:0] r;
    r = lat;
    if (we && sel == 2'd0) r[7:0]  = d;
    if (we && sel == 2'd1) r[15:8] = d;
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    logic base, fos, en, direct, ufe;
    logic [15:0] ln;
    if (!rst_n) begin
      m_cnt <= 0; m_lat <= 0; m_ctl <= 0; m_pre <= 0;
      m_s1 <= 0; m_s2 <= 0; m_prv <= 0; m_buz <= 0; m_uf <= 0;
    end else begin
      base   = low_speed ? ls_ce : 1'b1;
      fos    = src_fast ? 1'b1 : (base && m_pre == 4'd15);
      en     = f_count_en(m_ctl, fos, m_s2, m_prv);
      ln     = f_merge(m_lat, wr_en, wr_sel, wr_data);
      direct = wr_en && wr_sel < 2'd2 && !m_ctl[0];
      ufe    = !direct && en && m_cnt == 16'd0;
      if (base) m_pre <= m_pre + 4'd1;
      m_s1 <= ext_pin; m_s2 <= m_s1; m_prv <= m_s2;
      m_lat <= ln;
      if (direct || ufe) m_cnt <= ln;
      else if (en) m_cnt <= m_cnt - 16'd1;
      m_uf <= ufe;
      if (ufe && m_ctl[5:4] == 2'b01) m_buz <= ~m_buz;
      if (wr_en && wr_sel == 2'd2) m_ctl <= wr_data & 8'hF3;
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic ei;
    ei = m_ctl[6] ? (m_s2 & ~m_prv) : (~m_s2 & m_prv);
    chk(cur_req, "cnt_out", 32'(cnt_out), 32'(m_cnt));
    chk(cur_req, "rd_mode", 32'(rd_mode), 32'(m_ctl));
    chk(cur_req, "uf_irq", 32'(uf_irq), 32'(m_uf));
    chk(cur_req, "buz_p", 32'(buz_p), 32'(m_buz));
    chk(cur_req, "buz_n", 32'(buz_n), 32'(m_ctl[1] & ~m_buz));
    chk(cur_req, "edge_irq", 32'(edge_irq), 32'(ei));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic toggle_pin(int n, int period);
    for (int i = 0; i < n; i++) begin
      if (i % period == 0) ext_pin = ~ext_pin;
      tick();
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] hold;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "cnt_out", 32'(cnt_out), 0);
    chk("R1", "rd_mode", 32'(rd_mode), 0);
    chk("R1", "outputs", {28'd0, buz_p, buz_n, uf_irq, edge_irq}, 0);
    rst_n = 1;
    cur_req = "R3"; run(40);

    // R2: reserved bits read 0, select 3 ignored
    cur_req = "R2";
    wr(2'd2, 8'hFF);
    chk("R2", "rd_mode", 32'(rd_mode), 32'hF3);
    wr(2'd3, 8'h00);
    chk("R2", "rd_mode after sel3", 32'(rd_mode), 32'hF3);

    // R12: stop holds the counter against counting
    cur_req = "R12";
    wr(2'd2, 8'h80);
    wr(2'd0, 8'h40);
    src_fast = 1;
    hold = cnt_out;
    run(30);
    chk("R12", "cnt held", 32'(cnt_out), 32'(hold));

    // R4 / R5: full rate, direct write, underflow reload
    cur_req = "R4";
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h00);
    run(4);
    cur_req = "R5"; run(20);

    // R3: prescaled, normal then low-speed
    cur_req = "R3";
    src_fast = 0;
    wr(2'd0, 8'h02);
    run(120);
    low_speed = 1;
    for (int i = 0; i < 300; i++) begin ls_ce = ($urandom % 3) == 0; tick(); end
    low_speed = 0; ls_ce = 0;

    // R6: latch-only writes do not touch the counter
    cur_req = "R6";
    src_fast = 1;
    wr(2'd2, 8'h81);
    hold = cnt_out;
    wr(2'd0, 8'h07);
    chk("R6", "latch-only write", 32'(cnt_out), 32'(hold));
    wr(2'd2, 8'h01);
    run(30);

    // R7: high-byte write on the underflow cycle
    cur_req = "R7";
    wr(2'd0, 8'h03);
    for (int i = 0; i < 40 && cnt_out != 16'd0; i++) tick();
    wr(2'd1, 8'hA5);
    chk("R7", "reload with new high byte", 32'(cnt_out), 32'h0000A503);
    chk("R7", "uf_irq", 32'(uf_irq), 1);
    wr(2'd1, 8'h00);
    run(20);

    // R8: buzzer with and without complement
    cur_req = "R8";
    wr(2'd2, 8'h12);
    wr(2'd0, 8'h04);
    run(40);
    wr(2'd2, 8'h10);
    run(20);

    // R9 / R11: event counting on each polarity
    cur_req = "R9";
    src_fast = 0;
    wr(2'd2, 8'h20);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h00);
    toggle_pin(80, 3);
    cur_req = "R11";
    wr(2'd2, 8'h60);
    toggle_pin(80, 4);

    // R10: pulse width, both levels, both rates
    cur_req = "R10";
    src_fast = 1;
    wr(2'd2, 8'h30);
    toggle_pin(80, 7);
    wr(2'd2, 8'h70);
    toggle_pin(80, 9);
    src_fast = 0;
    toggle_pin(200, 25);

    // random mix across all modes
    cur_req = "R3 R4 R5 R6 R8 R9 R10 R11 random";
    for (int i = 0; i < 6000; i++) begin
      if ($urandom % 4 == 0) ext_pin = ~ext_pin;
      if ($urandom % 64 == 0) src_fast = ~src_fast;
      if ($urandom % 200 == 0) low_speed = ~low_speed;
      ls_ce = ($urandom % 3) == 0;
      if ($urandom % 30 == 0) begin
        wr_en = 1;
        wr_sel = 2'($urandom % 4);
        wr_data = 8'($urandom);
        if (wr_sel == 2'd1) wr_data = wr_data & 8'h01;
        if (wr_sel == 2'd2 && ($urandom % 4 != 0)) wr_data[7] = 1'b0;
      end else begin
        wr_en = 0;
      end
      tick();
    end
    wr_en = 0;
    run(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule